// File: doc/BRIEF.md
# Programmable Slot-Table Weighted Round-Robin Arbiter

This block picks one winner per clock among a set of requesters by walking a small table of slots. Each slot names one requester. In every cycle the arbiter looks through the slots in a circular order and grants the first slot whose named requester is asking. The table holds four slots per requester. Software can rewrite any slot through a one-word write port. Plain round-robin, weighted round-robin and fixed priority therefore all come from the same hardware. Repeating a requester in more slots raises its share. Reordering the slots changes who is served first.

A mode input selects how the walk starts. In rotating mode the walk resumes just past the slot that won last time. In top-start mode every walk begins at slot 0, so slot order becomes a programmable priority list. The grant appears combinationally in the same cycle as the requests. The pointer and table updates take effect at the next clock edge.

Top module: `slot_table_arbiter`

## Requirements
- R1: After reset, slot s holds requester number s mod NUM_REQ, and the first walk starts at slot 0. With every requester asking, the first grant goes to slot 0 (requester 0).
- R2: The grant is one-hot over `grantVec` (bit r means requester r). It is issued in the same cycle as the requests and only to a requester whose `reqVec` bit is high. `grantValid` is high exactly when a grant bit is set, and `grantSlot` gives the winning slot index.
- R3: In rotating mode (`fixedMode`=0), the walk starts at the slot after the last granted slot, wraps from the last slot to slot 0, and the first slot whose requester is asking wins.
- R4: In rotating mode, after a grant the pointer rests on the granted slot.
- R5: When no asking requester is named in any slot, no grant is issued and, in rotating mode, the pointer does not move.
- R6: A requester named in no slot is never granted, whatever the traffic.
- R7: With `tblWrEn` high at a clock edge, slot `tblWrSlot` takes the value `tblWrReq`. The grant in the cycle of the write still uses the old contents; the new value counts from the next cycle.
- R8: With all requesters asking in rotating mode, each requester receives, over one full pass of the slots, as many grants as the slots that name it.
- R9: In top-start mode (`fixedMode`=1), every walk begins at slot 0, so the earliest slot naming an asking requester wins. The pointer is parked on the last slot, so that a return to rotating mode resumes the walk at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_REQ | Request lines, bit r for requester r |
| fixedMode | input | 1 | 0 rotating walk, 1 walk always from slot 0 |
| tblWrEn | input | 1 | Slot write strobe |
| tblWrSlot | input | clog2(NUM_REQ*SLOTS_PER_REQ) | Slot index to write |
| tblWrReq | input | clog2(NUM_REQ) | Requester number stored into the slot |
| grantVec | output | NUM_REQ | One-hot grant |
| grantValid | output | 1 | A grant is issued this cycle |
| grantSlot | output | clog2(NUM_REQ*SLOTS_PER_REQ) | Index of the winning slot, meaningful with grantValid |

## Verification
The assertions assume that `reqVec`, `fixedMode` and the write port are stable around the clock edge. They also assume that, with NUM_REQ a power of two, every written requester number names a real requester. The stimulus changes inputs only on the falling edge and writes only numbers below NUM_REQ. Its sweeps cover the reset table, a weighted table, a table that omits one requester, a reversed table in top-start mode, and a long pseudo-random run in which writes overlap live requests. Each cycle is compared against a slot-walk model kept in the bench.

// File: rtl/sta_pkg.sv
package sta_pkg;

  // How the slot walk picks its first slot.
  typedef enum logic {
    SCAN_ROTATE   = 1'b0,
    SCAN_FROM_TOP = 1'b1
  } scanMode_e;

  // Strobes from the scan control to the slot-table datapath.
  typedef struct packed {
    logic tblWrite;   // commit the write port into the table at this edge
    logic selValid;   // the selected slot is a real winner this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/sta_slot_table.sv
module sta_slot_table
  import sta_pkg::*;
#(
  parameter int unsigned NUM_REQ       = 4,
  parameter int unsigned SLOTS_PER_REQ = 4,
  localparam int unsigned SLOTS  = NUM_REQ * SLOTS_PER_REQ,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned REQ_W  = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [SLOT_W-1:0]  wrSlot,
  input  logic [REQ_W-1:0]   wrReq,
  input  logic [SLOT_W-1:0]  selSlot,
  input  logic [NUM_REQ-1:0] reqVec,
  output logic [SLOTS-1:0]   hitVec,
  output logic [NUM_REQ-1:0] grantVec
);

  localparam logic [REQ_W:0] REQ_LIMIT = (REQ_W+1)'(NUM_REQ);

  logic [REQ_W-1:0]   slotTbl [SLOTS];
  logic [NUM_REQ-1:0] presentVec;

  // Table storage: reset to an ascending repeating pattern, then writable.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) begin
        slotTbl[s] <= REQ_W'(s % NUM_REQ);
      end
    end else if (strobe.tblWrite) begin
      slotTbl[wrSlot] <= wrReq;
    end
  end

  // Per-slot match: the named requester exists and is asking.
  for (genvar s = 0; s < SLOTS; s++) begin : g_hit
    always_comb begin
      hitVec[s] = 1'b0;
      if ({1'b0, slotTbl[s]} < REQ_LIMIT) begin
        hitVec[s] = reqVec[slotTbl[s]];
      end
    end
  end

  // Which requesters are named somewhere in the table.
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_present
    always_comb begin
      presentVec[r] = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        if (slotTbl[s] == REQ_W'(r)) presentVec[r] = 1'b1;
      end
    end
  end

  // Decode the winning slot into a one-hot grant.
  always_comb begin
    grantVec = '0;
    if (strobe.selValid) begin
      grantVec[slotTbl[selSlot]] = 1'b1;
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && (strobe.selValid == (|grantVec)));

  p_grant_asked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~reqVec) == '0);

  p_unlisted_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~presentVec) == '0);

endmodule

// File: rtl/sta_scan_ctrl.sv
module sta_scan_ctrl
  import sta_pkg::*;
#(
  parameter int unsigned NUM_REQ       = 4,
  parameter int unsigned SLOTS_PER_REQ = 4,
  localparam int unsigned SLOTS  = NUM_REQ * SLOTS_PER_REQ,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fixedMode,
  input  logic              tblWrEn,
  input  logic [SLOTS-1:0]  hitVec,
  output ctrlStrobe_t       strobe,
  output logic [SLOT_W-1:0] selSlot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  scanMode_e         scanMode;
  logic [SLOT_W-1:0] lastPtr;
  logic [SLOT_W-1:0] startSlot;
  logic              found;
  logic [SLOT_W-1:0] winSlot;
  int unsigned       probe;

  assign scanMode = scanMode_e'(fixedMode);

  // First slot of this walk.
  always_comb begin
    if (scanMode == SCAN_FROM_TOP || lastPtr == LAST_SLOT) startSlot = '0;
    else                                                   startSlot = lastPtr + 1'b1;
  end

  // Rotate-and-priority-encode over all slots in one cycle.
  always_comb begin
    found   = 1'b0;
    winSlot = '0;
    probe   = 0;
    for (int i = 0; i < SLOTS; i++) begin
      probe = int'(startSlot) + i;
      if (probe >= SLOTS) probe = probe - SLOTS;
      if (!found && hitVec[probe]) begin
        found   = 1'b1;
        winSlot = SLOT_W'(probe);
      end
    end
  end

  // Last-grant pointer.
  always_ff @(posedge clk) begin
    if (!rstN)                        lastPtr <= LAST_SLOT;
    else if (scanMode == SCAN_FROM_TOP) lastPtr <= LAST_SLOT;
    else if (found)                   lastPtr <= winSlot;
  end

  always_comb begin
    strobe.tblWrite = tblWrEn;
    strobe.selValid = found;
  end
  assign selSlot = winSlot;

  p_ptr_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selValid && !fixedMode) |=> lastPtr == $past(selSlot));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.selValid && !fixedMode) |=> $stable(lastPtr));

  p_top_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    fixedMode |=> startSlot == '0);

  p_ask_gets_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) == strobe.selValid);

endmodule

// File: rtl/slot_table_arbiter.sv
module slot_table_arbiter
  import sta_pkg::*;
#(
  parameter int unsigned NUM_REQ       = 4,
  parameter int unsigned SLOTS_PER_REQ = 4,
  localparam int unsigned SLOTS  = NUM_REQ * SLOTS_PER_REQ,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned REQ_W  = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               fixedMode,
  input  logic               tblWrEn,
  input  logic [SLOT_W-1:0]  tblWrSlot,
  input  logic [REQ_W-1:0]   tblWrReq,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               grantValid,
  output logic [SLOT_W-1:0]  grantSlot
);

  ctrlStrobe_t       strobe;
  logic [SLOTS-1:0]  hitVec;
  logic [SLOT_W-1:0] selSlot;

  sta_scan_ctrl #(
    .NUM_REQ      (NUM_REQ),
    .SLOTS_PER_REQ(SLOTS_PER_REQ)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fixedMode(fixedMode),
    .tblWrEn  (tblWrEn),
    .hitVec   (hitVec),
    .strobe   (strobe),
    .selSlot  (selSlot)
  );

  sta_slot_table #(
    .NUM_REQ      (NUM_REQ),
    .SLOTS_PER_REQ(SLOTS_PER_REQ)
  ) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrSlot  (tblWrSlot),
    .wrReq   (tblWrReq),
    .selSlot (selSlot),
    .reqVec  (reqVec),
    .hitVec  (hitVec),
    .grantVec(grantVec)
  );

  assign grantValid = strobe.selValid;
  assign grantSlot  = selSlot;

endmodule

// File: tb/tb_slot_table_arbiter.sv
`timescale 1ns/1ps
module tb_slot_table_arbiter;

  localparam int NR = 4;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] reqVec;
  logic       fixedMode;
  logic       tblWrEn;
  logic [3:0] tblWrSlot;
  logic [1:0] tblWrReq;
  logic [3:0] grantVec;
  logic       grantValid;
  logic [3:0] grantSlot;

  always #4 clk = ~clk;

  slot_table_arbiter #(.NUM_REQ(NR), .SLOTS_PER_REQ(4)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .fixedMode(fixedMode),
    .tblWrEn(tblWrEn), .tblWrSlot(tblWrSlot), .tblWrReq(tblWrReq),
    .grantVec(grantVec), .grantValid(grantValid), .grantSlot(grantSlot)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the slot walk.
  int mTbl[NS];
  int mLast;
  int obsReq;   // requester granted in the last cycle, -1 for none
  int obsSlot;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCycle(input logic [3:0] req, input logic mode,
                          input logic we, input int wslot, input int wreq,
                          input string tag);
    int start;
    int expSlot;
    int expReq;
    int idx;
    @(negedge clk);
    reqVec = req; fixedMode = mode; tblWrEn = we;
    tblWrSlot = 4'(wslot); tblWrReq = 2'(wreq);
    #1;
    start   = mode ? 0 : (mLast + 1) % NS;
    expSlot = -1;
    expReq  = -1;
    for (int i = 0; i < NS; i++) begin
      idx = (start + i) % NS;
      if (expSlot < 0 && req[mTbl[idx]]) begin
        expSlot = idx;
        expReq  = mTbl[idx];
      end
    end
    obsReq = -1;
    for (int r = 0; r < NR; r++) if (grantVec == 4'(1 << r)) obsReq = r;
    obsSlot = grantValid ? int'(grantSlot) : -1;
    chk(grantValid == (expSlot >= 0), tag, "grantValid", int'(grantValid), int'(expSlot >= 0));
    chk(grantVec == ((expReq >= 0) ? 4'(1 << expReq) : 4'b0), tag, "grantVec",
        int'(grantVec), (expReq >= 0) ? (1 << expReq) : 0);
    if (expSlot >= 0) chk(int'(grantSlot) == expSlot, tag, "grantSlot", int'(grantSlot), expSlot);
    if (mode) mLast = NS - 1;
    else if (expSlot >= 0) mLast = expSlot;
    if (we) mTbl[wslot] = wreq;
  endtask

  task automatic writeSlot(input int s, input int r, input logic mode);
    runCycle(4'b0000, mode, 1'b1, s, r, "R7");
  endtask

  int cnt[NR];
  logic [7:0] lfsr;

  initial begin
    rstN = 1'b0; reqVec = '0; fixedMode = 1'b0; tblWrEn = 1'b0;
    tblWrSlot = '0; tblWrReq = '0;
    for (int s = 0; s < NS; s++) mTbl[s] = s % NR;
    mLast = NS - 1;
    repeat (3) @(posedge clk);
    #1;
    chk(grantValid == 1'b0 && grantVec == 4'b0, "R1", "idle in reset", int'(grantVec), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R5: nobody asking
    runCycle(4'b0000, 1'b0, 1'b0, 0, 0, "R5");
    // R1: first grant with all asking is slot 0, requester 0
    runCycle(4'b1111, 1'b0, 1'b0, 0, 0, "R1");
    chk(obsSlot == 0 && obsReq == 0, "R1", "first slot", obsSlot, 0);
    // R4: next walk continues at slot 1
    runCycle(4'b1111, 1'b0, 1'b0, 0, 0, "R4");
    chk(obsSlot == 1, "R4", "pointer advance", obsSlot, 1);

    // R3/R5: sweep every request pattern on the reset table
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 9; c++) begin
        if (c % 3 == 2) runCycle(4'b0000, 1'b0, 1'b0, 0, 0, "R5");
        else            runCycle(4'(p), 1'b0, 1'b0, 0, 0, "R3");
      end
    end

    // R8: weighted table 7/5/3/1
    for (int s = 0; s < NS; s++) writeSlot(s, (s < 7) ? 0 : (s < 12) ? 1 : (s < 15) ? 2 : 3, 1'b0);
    for (int r = 0; r < NR; r++) cnt[r] = 0;
    for (int c = 0; c < NS; c++) begin
      runCycle(4'b1111, 1'b0, 1'b0, 0, 0, "R8");
      if (obsReq >= 0) cnt[obsReq]++;
    end
    chk(cnt[0] == 7, "R8", "share req0", cnt[0], 7);
    chk(cnt[1] == 5, "R8", "share req1", cnt[1], 5);
    chk(cnt[2] == 3, "R8", "share req2", cnt[2], 3);
    chk(cnt[3] == 1, "R8", "share req3", cnt[3], 1);

    // R7: write during a live arbitration in top-start mode
    runCycle(4'b1111, 1'b1, 1'b1, 0, 3, "R7");
    chk(obsReq == 0, "R7", "old contents in write cycle", obsReq, 0);
    runCycle(4'b1111, 1'b1, 1'b0, 0, 0, "R7");
    chk(obsReq == 3, "R7", "new contents next cycle", obsReq, 3);

    // R6: table without requester 3
    for (int s = 0; s < NS; s++) writeSlot(s, s % 3, 1'b0);
    for (int c = 0; c < 8; c++) begin
      runCycle(4'b1000, 1'b0, 1'b0, 0, 0, "R6");
      chk(obsReq == -1, "R6", "unlisted alone", obsReq, -1);
    end
    cnt[3] = 0;
    for (int c = 0; c < 48; c++) begin
      runCycle(4'b1111, 1'b0, 1'b0, 0, 0, "R6");
      if (obsReq == 3) cnt[3]++;
    end
    chk(cnt[3] == 0, "R6", "unlisted under load", cnt[3], 0);

    // R9: reversed table, top-start mode gives highest index first
    for (int s = 0; s < NS; s++) writeSlot(s, 3 - (s % 4), 1'b1);
    for (int p = 1; p < 16; p++) begin
      int hi;
      hi = -1;
      for (int r = 0; r < NR; r++) if (p[r]) hi = r;
      for (int c = 0; c < 3; c++) begin
        runCycle(4'(p), 1'b1, 1'b0, 0, 0, "R9");
        chk(obsReq == hi, "R9", "fixed priority winner", obsReq, hi);
      end
    end
    runCycle(4'b1111, 1'b0, 1'b0, 0, 0, "R9");
    chk(obsSlot == 0, "R9", "rotate resumes at slot 0", obsSlot, 0);

    // R2/R3/R7: pseudo-random traffic with overlapping writes
    lfsr = 8'h5A;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      runCycle(lfsr[3:0], (c % 200) > 170, (lfsr[7:5] == 3'b101), int'(lfsr[6:3]),
               int'(lfsr[1:0]), "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule